// File: doc/BRIEF.md
# Descriptor ring queue controller

This block is the register-side queue manager for a DMA engine that works through a circular ring of descriptors held in memory. Software sets up the ring through a 32-bit register bus: a base address, a ring length, a descriptor size, and a completion-message address, payload and threshold. After that, software never touches a pointer. It posts work by writing a count of freshly written descriptors. It hands finished descriptors back by writing a count. It learns progress by reading one packed status word, which holds the number of finished-but-unreleased descriptors and the ring index of the oldest of them.

Toward the engine, the block presents one fetch request at a time. Each request carries the ring index and the byte address of the next descriptor, and the engine accepts it with an acknowledge. The engine reports each finished descriptor with a done strobe, together with that descriptor's interrupt-on-done bit. When such a bit is set and enough finished work has piled up, the block emits a one-cycle completion message carrying the programmed address and payload. Posting more than the ring can hold is trimmed to fit and leaves a sticky error flag.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the engine is stopped (offset 0x800 reads 1), the status word at 0x00C reads 0, the descriptor-size register at 0x100 reads 1, and fetchReq, msgValid and ovfErr are low.
- R2: Configuration readback works as follows. Offset 0x000 returns all 32 bits written, and 0x004 returns only bits [15:0] of what was written. Offset 0x008 holds the ring length in bits [15:0]. Offset 0x018 holds the threshold in bits [14:0]. Offset 0x014 holds the message payload (32 bits). Offsets 0x050 and 0x054 hold the message address, low 32 bits and high 16 bits.
- R3: Writing 0 to 0x800 starts the engine and writing any other value stops it. While stopped, fetchReq stays low and the counters keep their values. Posted work is fetched once the engine is started again.
- R4: A count N written to 0x808 makes N more descriptors available. While running, fetchReq is high whenever any descriptor is available. fetchIdx gives its ring index, and fetchAddr equals base + fetchIdx × descriptor bytes. Each cycle with fetchReq and fetchAck both high consumes one descriptor and advances the index.
- R5: The fetch index and the retire index both wrap to 0 on reaching the effective ring length.
- R6: A doneStb while at least one fetched descriptor is unfinished raises the done count in bits [14:0] of 0x00C by one. A doneStb with nothing in flight is ignored.
- R7: A count N written to 0x804 lowers the done count by N, clamped to the done count. It advances the retire index, reported in bits [28:16] of 0x00C, by the same amount.
- R8: Posted, in-flight and done descriptors together never exceed the effective ring length. A count written to 0x808 that would exceed it is trimmed to the free room and sets ovfErr, which stays set until reset.
- R9: Writing 7 to 0x100 selects 128-byte descriptors with a ring limit of 4096 entries. Any other value selects 32-byte descriptors with a limit of 16384. The effective ring length is the smaller of the written length and that limit.
- R10: msgValid pulses for one cycle, in the cycle after a counted doneStb with doneIod high, only when the done count including that descriptor is at least the threshold. msgAddr and msgData then carry the programmed message address and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| fetchReq | output | 1 | A descriptor is ready to be fetched |
| fetchAck | input | 1 | Engine takes the offered descriptor |
| fetchIdx | output | IDX_W (14) | Ring index of the offered descriptor |
| fetchAddr | output | ADDR_W (48) | Byte address of the offered descriptor |
| doneStb | input | 1 | Engine finished the oldest in-flight descriptor |
| doneIod | input | 1 | Interrupt-on-done bit of that descriptor |
| msgValid | output | 1 | Completion message strobe |
| msgAddr | output | ADDR_W (48) | Completion message address |
| msgData | output | 32 | Completion message payload |
| ovfErr | output | 1 | Sticky over-posting flag |

## Verification
Register reads are combinational, so a written value or a count change caused by a write, a fetch acknowledge or a done strobe is visible in the status word from the first falling edge after the clock edge that took it. fetchReq follows the available count and the run state with no added delay, so it rises one cycle after the add or start write. msgValid is registered and is high only in the single cycle after the done strobe's edge. The bench drives every input on a falling edge and samples exactly one falling edge after the active edge. For the message, it checks both that cycle and the one after it.

// File: rtl/drq_pkg.sv
package drq_pkg;
  localparam int AMT_W = 16;

  // register byte offsets
  localparam logic [11:0] OFF_BASE_LO = 12'h000;
  localparam logic [11:0] OFF_BASE_HI = 12'h004;
  localparam logic [11:0] OFF_RING_LEN = 12'h008;
  localparam logic [11:0] OFF_STATUS  = 12'h00C;
  localparam logic [11:0] OFF_MSG_DAT = 12'h014;
  localparam logic [11:0] OFF_THRESH  = 12'h018;
  localparam logic [11:0] OFF_MSG_LO  = 12'h050;
  localparam logic [11:0] OFF_MSG_HI  = 12'h054;
  localparam logic [11:0] OFF_DSIZE   = 12'h100;
  localparam logic [11:0] OFF_HALT    = 12'h800;
  localparam logic [11:0] OFF_RELEASE = 12'h804;
  localparam logic [11:0] OFF_POST    = 12'h808;

  localparam logic [2:0] DSIZE_WIDE = 3'd7;

  // strobes from the register side to the counters
  typedef struct packed {
    logic postStb;
    logic releaseStb;
    logic [AMT_W-1:0] amount;
  } drqStrobe_t;
endpackage

// File: rtl/drq_regs.sv
module drq_regs
  import drq_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int ADDR_W = 48,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [CNT_W-1:0]  doneCnt,
  input  logic [IDX_W-1:0]  retirePtr,
  output drqStrobe_t        stb,
  output logic              running,
  output logic              wideDesc,
  output logic [CNT_W-1:0]  effSize,
  output logic [14:0]       thresh,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [31:0]       msgData
);
  localparam int CAP_NARROW = ((2 ** IDX_W) < 16384) ? (2 ** IDX_W) : 16384;
  localparam int CAP_WIDE   = ((2 ** IDX_W) < 4096) ? (2 ** IDX_W) : 4096;

  logic [31:0] baseLo, msgLo;
  logic [15:0] baseHi, msgHi, ringLen;
  logic [2:0]  dSize;
  logic [31:0] capV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo  <= '0;
      baseHi  <= '0;
      ringLen <= '0;
      thresh  <= '0;
      msgLo   <= '0;
      msgHi   <= '0;
      msgData <= '0;
      dSize   <= 3'd1;
      running <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        OFF_BASE_LO:  baseLo  <= regWrData;
        OFF_BASE_HI:  baseHi  <= regWrData[15:0];
        OFF_RING_LEN: ringLen <= regWrData[15:0];
        OFF_THRESH:   thresh  <= regWrData[14:0];
        OFF_MSG_DAT:  msgData <= regWrData;
        OFF_MSG_LO:   msgLo   <= regWrData;
        OFF_MSG_HI:   msgHi   <= regWrData[15:0];
        OFF_DSIZE:    dSize   <= regWrData[2:0];
        OFF_HALT:     running <= (regWrData == 32'd0);
        default: ;
      endcase
    end
  end

  assign wideDesc = (dSize == DSIZE_WIDE);
  assign capV     = wideDesc ? 32'(CAP_WIDE) : 32'(CAP_NARROW);
  assign effSize  = CNT_W'((32'(ringLen) > capV) ? capV : 32'(ringLen));
  assign baseAddr = ADDR_W'({baseHi, baseLo});
  assign msgAddr  = ADDR_W'({msgHi, msgLo});

  assign stb.postStb    = regWrEn && (regAddr == OFF_POST);
  assign stb.releaseStb = regWrEn && (regAddr == OFF_RELEASE);
  assign stb.amount     = regWrData[AMT_W-1:0];

  always_comb begin
    case (regAddr)
      OFF_BASE_LO:  regRdData = baseLo;
      OFF_BASE_HI:  regRdData = {16'd0, baseHi};
      OFF_RING_LEN: regRdData = {16'd0, ringLen};
      OFF_STATUS:   regRdData = {3'd0, 13'(retirePtr), 1'b0, 15'(doneCnt)};
      OFF_MSG_DAT:  regRdData = msgData;
      OFF_THRESH:   regRdData = {17'd0, thresh};
      OFF_MSG_LO:   regRdData = msgLo;
      OFF_MSG_HI:   regRdData = {16'd0, msgHi};
      OFF_DSIZE:    regRdData = {29'd0, dSize};
      OFF_HALT:     regRdData = {31'd0, ~running};
      default:      regRdData = 32'd0;
    endcase
  end

  // R3: a write to the halt register sets the run state from its value
  a_r3_halt_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_HALT) |=> (running == $past(regWrData == 32'd0)));
endmodule

// File: rtl/drq_datapath.sv
module drq_datapath
  import drq_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int ADDR_W = 48,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  drqStrobe_t        stb,
  input  logic              running,
  input  logic              wideDesc,
  input  logic [CNT_W-1:0]  effSize,
  input  logic [14:0]       thresh,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              fetchAck,
  input  logic              doneStb,
  input  logic              doneIod,
  output logic              fetchReq,
  output logic [IDX_W-1:0]  fetchIdx,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              msgValid,
  output logic              ovfErr,
  output logic [CNT_W-1:0]  doneCnt,
  output logic [IDX_W-1:0]  retirePtr
);
  logic [CNT_W-1:0] availCnt, inflight;
  logic [IDX_W-1:0] fetchPtr;
  logic [31:0] outst, room, amt, postAmt, relAmt;
  logic fetchFire, doneHit, postOver;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] p,
                                               input logic [31:0] n,
                                               input logic [CNT_W-1:0] sz);
    logic [31:0] s;
    s = 32'(p) + n;
    if (s >= 32'(sz)) s = s - 32'(sz);
    return IDX_W'(s);
  endfunction

  assign fetchReq  = running && (availCnt != '0);
  assign fetchFire = fetchReq && fetchAck;
  assign doneHit   = doneStb && (inflight != '0);
  assign fetchIdx  = fetchPtr;
  assign fetchAddr = baseAddr + (ADDR_W'(fetchPtr) << (wideDesc ? 7 : 5));

  always_comb begin
    outst    = 32'(availCnt) + 32'(inflight) + 32'(doneCnt);
    room     = (32'(effSize) > outst) ? 32'(effSize) - outst : 32'd0;
    amt      = 32'(stb.amount);
    postOver = stb.postStb && (amt > room);
    postAmt  = !stb.postStb ? 32'd0 : (postOver ? room : amt);
    relAmt   = !stb.releaseStb ? 32'd0 :
               ((amt > 32'(doneCnt)) ? 32'(doneCnt) : amt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      availCnt  <= '0;
      inflight  <= '0;
      doneCnt   <= '0;
      fetchPtr  <= '0;
      retirePtr <= '0;
      ovfErr    <= 1'b0;
      msgValid  <= 1'b0;
    end else begin
      availCnt <= CNT_W'(32'(availCnt) + postAmt - 32'(fetchFire));
      inflight <= CNT_W'(32'(inflight) + 32'(fetchFire) - 32'(doneHit));
      doneCnt  <= CNT_W'(32'(doneCnt) + 32'(doneHit) - relAmt);
      if (fetchFire) fetchPtr <= wrapAdd(fetchPtr, 32'd1, effSize);
      if (stb.releaseStb) retirePtr <= wrapAdd(retirePtr, relAmt, effSize);
      if (postOver) ovfErr <= 1'b1;
      msgValid <= doneHit && doneIod && ((32'(doneCnt) + 32'd1) >= 32'(thresh));
    end
  end

  // R3: no fetch while stopped, so the fetch index holds
  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> $stable(fetchIdx));
  // R5: an offered index always lies inside the ring
  a_r5_idx_in_ring: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (32'(fetchIdx) < 32'(effSize)));
  // R6: the done count only grows on a done strobe
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    (doneCnt > $past(doneCnt)) |-> $past(doneStb));
  // R8: occupancy bound and sticky flag
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (32'(availCnt) + 32'(inflight) + 32'(doneCnt)) <= 32'(effSize));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(ovfErr) |-> ovfErr);
  // R10: a message follows a flagged done strobe
  a_r10_msg_cause: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(doneStb && doneIod));
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import drq_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              fetchReq,
  input  logic              fetchAck,
  output logic [IDX_W-1:0]  fetchIdx,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              doneStb,
  input  logic              doneIod,
  output logic              msgValid,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [31:0]       msgData,
  output logic              ovfErr
);
  localparam int CNT_W = IDX_W + 1;

  drqStrobe_t stb;
  logic running, wideDesc;
  logic [CNT_W-1:0] effSize, doneCnt;
  logic [IDX_W-1:0] retirePtr;
  logic [14:0] thresh;
  logic [ADDR_W-1:0] baseAddr;

  drq_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneCnt(doneCnt),
    .retirePtr(retirePtr), .stb(stb), .running(running), .wideDesc(wideDesc),
    .effSize(effSize), .thresh(thresh), .baseAddr(baseAddr),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  drq_datapath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .running(running), .wideDesc(wideDesc),
    .effSize(effSize), .thresh(thresh), .baseAddr(baseAddr),
    .fetchAck(fetchAck), .doneStb(doneStb), .doneIod(doneIod),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx), .fetchAddr(fetchAddr),
    .msgValid(msgValid), .ovfErr(ovfErr), .doneCnt(doneCnt),
    .retirePtr(retirePtr)
  );
endmodule

// File: tb/tb_desc_ring_ctrl.sv
module tb_desc_ring_ctrl;
  localparam int CLK_P = 10;
  localparam logic [47:0] BASE = 48'h0012_3456_7000;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, fetchAck = 1'b0, doneStb = 1'b0, doneIod = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData, msgData;
  logic fetchReq, msgValid, ovfErr;
  logic [13:0] fetchIdx;
  logic [47:0] fetchAddr, msgAddr;
  int nChecks = 0, nErr = 0;

  always #(CLK_P / 2) clk = ~clk;

  desc_ring_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchReq(fetchReq),
    .fetchAck(fetchAck), .fetchIdx(fetchIdx), .fetchAddr(fetchAddr),
    .doneStb(doneStb), .doneIod(doneIod), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData), .ovfErr(ovfErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, 64'(regRdData), 64'(exp));
  endtask

  task automatic ackOne(input string req, input int idx, input int bytes);
    @(negedge clk);
    chk(req, 64'(fetchReq), 64'd1);
    chk(req, 64'(fetchIdx), 64'(idx));
    chk(req, 64'(fetchAddr), 64'(BASE + 48'(idx * bytes)));
    fetchAck = 1'b1;
    @(negedge clk);
    fetchAck = 1'b0;
  endtask

  task automatic doneOne(input logic iod);
    @(negedge clk);
    doneStb = 1'b1; doneIod = iod;
    @(negedge clk);
    doneStb = 1'b0; doneIod = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) doneOne(1'b0);
    wr(12'h804, 32'(n));
  endtask

  // R1
  task automatic tReset();
    rdChk("R1 status", 12'h00C, 32'd0);
    rdChk("R1 halted", 12'h800, 32'd1);
    rdChk("R1 dsize", 12'h100, 32'd1);
    chk("R1 fetchReq", 64'(fetchReq), 64'd0);
    chk("R1 msgValid", 64'(msgValid), 64'd0);
    chk("R1 ovfErr", 64'(ovfErr), 64'd0);
  endtask

  // R2
  task automatic tConfig();
    wr(12'h000, 32'h3456_7000); rdChk("R2 base lo", 12'h000, 32'h3456_7000);
    wr(12'h004, 32'hFFFF_0012); rdChk("R2 base hi", 12'h004, 32'h0000_0012);
    wr(12'h018, 32'hFFFF_FFFF); rdChk("R2 thresh", 12'h018, 32'h0000_7FFF);
    wr(12'h014, 32'hCAFE_F00D); rdChk("R2 msg data", 12'h014, 32'hCAFE_F00D);
    wr(12'h050, 32'h8000_0040); rdChk("R2 msg lo", 12'h050, 32'h8000_0040);
    wr(12'h054, 32'h1234_00AB); rdChk("R2 msg hi", 12'h054, 32'h0000_00AB);
    chk("R2 msgAddr port", 64'(msgAddr), 64'h00AB_8000_0040);
    wr(12'h008, 32'd5); rdChk("R2 ring len", 12'h008, 32'd5);
  endtask

  // R3, R4
  task automatic tHaltAndFetch();
    wr(12'h808, 32'd2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 stopped no fetch", 64'(fetchReq), 64'd0);
    end
    rdChk("R3 counters kept", 12'h00C, 32'd0);
    wr(12'h800, 32'd0);
    rdChk("R3 running", 12'h800, 32'd0);
    ackOne("R4 fetch 0", 0, 32);
    ackOne("R4 fetch 1", 1, 32);
    @(negedge clk);
    chk("R4 none left", 64'(fetchReq), 64'd0);
    wr(12'h800, 32'd1);
    wr(12'h808, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 restopped", 64'(fetchReq), 64'd0);
    end
    wr(12'h800, 32'd0);
    ackOne("R3 resume fetch", 2, 32);
  endtask

  // R6, R7
  task automatic tDoneRelease();
    for (int i = 0; i < 3; i++) doneOne(1'b0);
    rdChk("R6 done count", 12'h00C, 32'h0000_0003);
    doneOne(1'b0);
    rdChk("R6 stray done ignored", 12'h00C, 32'h0000_0003);
    wr(12'h804, 32'd1);
    rdChk("R7 release one", 12'h00C, 32'h0001_0002);
    wr(12'h804, 32'd9);
    rdChk("R7 release clamped", 12'h00C, 32'h0003_0000);
  endtask

  // R5
  task automatic tWrap();
    wr(12'h808, 32'd5);
    ackOne("R5 idx 3", 3, 32);
    ackOne("R5 idx 4", 4, 32);
    ackOne("R5 wrap to 0", 0, 32);
    ackOne("R5 idx 1", 1, 32);
    ackOne("R5 idx 2", 2, 32);
    drain(5);
    rdChk("R5 retire wrap", 12'h00C, 32'h0003_0000);
  endtask

  // R8
  task automatic tOverflow();
    int got;
    wr(12'h800, 32'd1);
    wr(12'h808, 32'd4);
    chk("R8 no ovf yet", 64'(ovfErr), 64'd0);
    wr(12'h808, 32'd3);
    chk("R8 ovf set", 64'(ovfErr), 64'd1);
    wr(12'h800, 32'd0);
    got = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      fetchAck = 1'b0;
      if (fetchReq) begin
        got++;
        fetchAck = 1'b1;
      end
    end
    @(negedge clk);
    fetchAck = 1'b0;
    chk("R8 trimmed to room", 64'(got), 64'd5);
    drain(5);
    chk("R8 ovf sticky", 64'(ovfErr), 64'd1);
  endtask

  // R10
  task automatic tMessage();
    wr(12'h018, 32'd2);
    wr(12'h808, 32'd3);
    ackOne("R10 f0", 3, 32);
    ackOne("R10 f1", 4, 32);
    ackOne("R10 f2", 0, 32);
    doneOne(1'b1);
    chk("R10 below threshold", 64'(msgValid), 64'd0);
    doneOne(1'b0);
    chk("R10 no iod", 64'(msgValid), 64'd0);
    doneOne(1'b1);
    chk("R10 msg pulse", 64'(msgValid), 64'd1);
    chk("R10 msg addr", 64'(msgAddr), 64'h00AB_8000_0040);
    chk("R10 msg data", 64'(msgData), 64'hCAFE_F00D);
    @(negedge clk);
    chk("R10 single cycle", 64'(msgValid), 64'd0);
    wr(12'h804, 32'd3);
    rdChk("R10 released", 12'h00C, 32'h0001_0000);
  endtask

  // R9
  task automatic tDescSize();
    wr(12'h100, 32'd7);
    rdChk("R9 dsize", 12'h100, 32'd7);
    wr(12'h808, 32'd1);
    ackOne("R9 wide stride", 1, 128);
    drain(1);
    doReset();
    wr(12'h100, 32'd7);
    wr(12'h008, 32'd5000);
    rdChk("R9 raw length", 12'h008, 32'd5000);
    wr(12'h808, 32'd4096);
    chk("R9 wide fits cap", 64'(ovfErr), 64'd0);
    wr(12'h808, 32'd1);
    chk("R9 wide cap 4096", 64'(ovfErr), 64'd1);
    doReset();
    wr(12'h008, 32'd5000);
    wr(12'h808, 32'd4097);
    chk("R9 narrow not capped at 4096", 64'(ovfErr), 64'd0);
    doReset();
    wr(12'h008, 32'd20000);
    wr(12'h808, 32'd16384);
    chk("R9 narrow fits cap", 64'(ovfErr), 64'd0);
    wr(12'h808, 32'd1);
    chk("R9 narrow cap 16384", 64'(ovfErr), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    tReset();
    tConfig();
    tHaltAndFetch();
    tDoneRelease();
    tWrap();
    tOverflow();
    tMessage();
    tDescSize();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule